// File: doc/BRIEF.md
# Bank Address Latch and Decoder

This block is glue logic beside a 65816-style processor whose data bus carries the bank byte while the CPU clock (PHI2) is low. A transparent latch, opened by the inverted PHI2 inside the block, takes that byte from the data bus. It holds the byte frozen for the whole high phase, when the bus carries ordinary read or write data. No second or delayed clock is needed.

The held bank byte drives three decodes. Eight one-hot bank selects cover the 64 KiB banks 0 to 7. An A16 line is taken from bit 0 of the held byte. A boot-device select covers the window `$FFC0`..`$FFFF` of bank 0. That window includes the 32-byte vector area `$FFE0`..`$FFFF`, so both native and emulation vectors are served by the boot device. Because every decode uses the held bank rather than the live bus, the selects stay valid through the high phase.

All pins are plain control and address signals. The block has no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `bank_sel_unit`

## Requirements
- R1: While `phi2` is low (and `rst_n` high), `bank_q` follows `data_bus` transparently, including changes made within the same low phase.
- R2: While `phi2` is high, `bank_q` keeps the value present on `data_bus` at the rising edge of `phi2`, whatever `data_bus` does. It changes again only after the next falling edge.
- R3: When `bank_q` is below 8, exactly one bit of `bank_sel` is 1, namely bit number `bank_q` (bit i selects bank i).
- R4: When `bank_q` is 8 or more, all eight bits of `bank_sel` are 0.
- R5: `a16` equals bit 0 of `bank_q` at all times.
- R6: `boot_sel` is 1 exactly when `bank_q` is 0 and `addr` lies in `$FFC0`..`$FFFF`, which includes the vector area `$FFE0`..`$FFFF`. It is 0 for any other bank or address, such as `$FFBF` in bank 0 or `$FFFF` in bank 1.
- R7: During the `phi2` high phase, `boot_sel` is decided by the held bank. A zero or non-zero byte on `data_bus` in that phase has no effect on it.
- R8: An active-low `rst_n` clears `bank_q` to 0 at once, in either clock phase. This makes `bank_sel` equal to `8'b0000_0001`, and the held value stays 0 until the first low phase after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| phi2 | input | 1 | CPU clock; low phase carries the bank byte |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_bus | input | 8 | Multiplexed CPU data bus |
| addr | input | 16 | CPU address A15..A0 |
| bank_q | output | 8 | Held bank byte |
| bank_sel | output | 8 | One-hot select, bit i for bank i |
| a16 | output | 1 | Synthesized address line A16 |
| boot_sel | output | 1 | Boot device select for bank 0, `$FFC0`..`$FFFF` |

## Verification
Each cycle drives a bank byte during the low phase and a deliberately different byte during the high phase. A design that latches on the wrong phase, or stays transparent, therefore shows the wrong bank. Some low phases change the byte twice, which separates a transparent latch from an edge-sampled flop. Bank values 0 to 7, 8, `$80` and `$FF` separate the one-hot decode from out-of-range handling and test A16 on odd values. Addresses `$FFBF`, `$FFC0`, `$FFE0` and `$FFFF` are tried in banks 0 and 1 to pin the window edges and the bank qualification. A reset pulse inside a high phase shows that the clear is asynchronous.

// File: rtl/bank_pkg.sv
package bank_pkg;
  localparam int unsigned BANK_DATA_W = 8;
  localparam int unsigned BANK_ADDR_W = 16;
  localparam int unsigned BANK_COUNT  = 8;
  localparam logic [15:0] BOOT_WIN_LO = 16'hFFC0;
endpackage

// File: rtl/bank_hold_latch.sv
module bank_hold_latch #(
  parameter int unsigned DATA_W = bank_pkg::BANK_DATA_W
) (
  input  logic              phi2,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] q
);
  // Latch enable is the inverted CPU clock, made inside the block.
  logic open_n;
  assign open_n = ~phi2;

  always_latch begin
    if (!rst_n)
      q = '0;
    else if (open_n)
      q = din;
  end
endmodule

// File: rtl/bank_onehot_dec.sv
module bank_onehot_dec #(
  parameter int unsigned DATA_W = bank_pkg::BANK_DATA_W,
  parameter int unsigned NBANK  = bank_pkg::BANK_COUNT
) (
  input  logic [DATA_W-1:0] bank,
  output logic [NBANK-1:0]  sel
);
  // Full-width compare, so values >= NBANK hit no select.
  for (genvar g = 0; g < NBANK; g++) begin : g_sel
    localparam logic [DATA_W-1:0] MATCH = DATA_W'(g);
    assign sel[g] = (bank == MATCH);
  end
endmodule

// File: rtl/boot_window_dec.sv
module boot_window_dec #(
  parameter int unsigned DATA_W = bank_pkg::BANK_DATA_W,
  parameter int unsigned ADDR_W = bank_pkg::BANK_ADDR_W,
  parameter logic [ADDR_W-1:0] WIN_LO = bank_pkg::BOOT_WIN_LO
) (
  input  logic [DATA_W-1:0] bank,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  logic bank_zero;
  logic in_win;
  // Window runs from WIN_LO to the top of the address space.
  assign bank_zero = (bank == '0);
  assign in_win    = (addr >= WIN_LO);
  assign hit       = bank_zero & in_win;
endmodule

// File: rtl/bank_sel_unit.sv
module bank_sel_unit #(
  parameter int unsigned DATA_W = bank_pkg::BANK_DATA_W,
  parameter int unsigned ADDR_W = bank_pkg::BANK_ADDR_W,
  parameter int unsigned NBANK  = bank_pkg::BANK_COUNT
) (
  input  logic              phi2,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] data_bus,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] bank_q,
  output logic [NBANK-1:0]  bank_sel,
  output logic              a16,
  output logic              boot_sel
);
  bank_hold_latch #(.DATA_W(DATA_W)) u_latch (
    .phi2 (phi2),
    .rst_n(rst_n),
    .din  (data_bus),
    .q    (bank_q)
  );

  bank_onehot_dec #(.DATA_W(DATA_W), .NBANK(NBANK)) u_dec (
    .bank(bank_q),
    .sel (bank_sel)
  );

  boot_window_dec #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_boot (
    .bank(bank_q),
    .addr(addr),
    .hit (boot_sel)
  );

  assign a16 = bank_q[0];
endmodule

// File: rtl/bank_sel_unit_chk.sv
module bank_sel_unit_chk #(
  parameter int unsigned DATA_W = bank_pkg::BANK_DATA_W,
  parameter int unsigned ADDR_W = bank_pkg::BANK_ADDR_W,
  parameter int unsigned NBANK  = bank_pkg::BANK_COUNT
) (
  input logic              phi2,
  input logic              rst_n,
  input logic [DATA_W-1:0] data_bus,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] bank_q,
  input logic [NBANK-1:0]  bank_sel,
  input logic              a16,
  input logic              boot_sel
);
  logic [DATA_W-1:0] rise_bus;
  logic              rise_seen;

  always_ff @(posedge phi2 or negedge rst_n) begin
    if (!rst_n) begin
      rise_bus  <= '0;
      rise_seen <= 1'b0;
    end else begin
      rise_bus  <= data_bus;
      rise_seen <= 1'b1;
    end
  end

  // R2
  hold_high_chk: assert property (@(negedge phi2) disable iff (!rst_n)
    rise_seen |-> (bank_q == rise_bus));

  // R5
  a16_held_chk: assert property (@(negedge phi2) disable iff (!rst_n)
    rise_seen |-> (a16 == rise_bus[0]));

  // R3
  one_sel_chk: assert property (@(posedge phi2) disable iff (!rst_n)
    (bank_q < NBANK) |-> ($countones(bank_sel) == 1));

  // R4
  no_sel_chk: assert property (@(posedge phi2) disable iff (!rst_n)
    (bank_q >= NBANK) |-> (bank_sel == '0));

  // R6
  boot_qual_chk: assert property (@(posedge phi2) disable iff (!rst_n)
    boot_sel |-> ((bank_q == '0) && (addr[ADDR_W-1:6] == '1)));

  // R8
  always @(posedge phi2) begin
    if (!rst_n) begin
      reset_clear_chk: assert (bank_q == '0 && bank_sel[0]);
    end
  end
endmodule

bind bank_sel_unit bank_sel_unit_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NBANK(NBANK)
) u_chk (
  .phi2(phi2), .rst_n(rst_n), .data_bus(data_bus), .addr(addr),
  .bank_q(bank_q), .bank_sel(bank_sel), .a16(a16), .boot_sel(boot_sel)
);

// File: tb/bank_sel_unit_test.sv
`timescale 1ns/1ps
module bank_sel_unit_test;
  logic        phi2 = 1'b1;
  logic        rst_n = 1'b0;
  logic [7:0]  data_bus = 8'h00;
  logic [15:0] addr = 16'h0000;
  logic [7:0]  bank_q;
  logic [7:0]  bank_sel;
  logic        a16;
  logic        boot_sel;

  int vectors = 0;
  int misses  = 0;
  int exp_bank = 0;

  always #4 phi2 = ~phi2;  // 125 MHz

  bank_sel_unit uut (
    .phi2(phi2), .rst_n(rst_n), .data_bus(data_bus), .addr(addr),
    .bank_q(bank_q), .bank_sel(bank_sel), .a16(a16), .boot_sel(boot_sel)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: integer arithmetic on the expected held bank.
  task automatic compare(input string phase);
    int exp_sel;
    int exp_boot;
    exp_sel  = (exp_bank < 8) ? (1 << exp_bank) : 0;
    exp_boot = (exp_bank == 0 && int'(addr) >= 'hFFC0) ? 1 : 0;
    chk({phase, " R1 R2 bank"}, int'(bank_q), exp_bank);
    chk({phase, " R3 R4 sel"}, int'(bank_sel), exp_sel);
    chk({phase, " R5 a16"}, int'(a16), exp_bank & 1);
    chk({phase, " R6 R7 boot"}, int'(boot_sel), exp_boot);
  endtask

  // One bus cycle: bank byte in low phase (optionally changed mid-phase),
  // unrelated byte in high phase.
  task automatic cycle(input logic [7:0] bnk, input logic [7:0] bnk2,
                       input logic [7:0] junk, input logic [15:0] a);
    @(negedge phi2);
    #1 data_bus = bnk; addr = a; exp_bank = bnk;
    #1 compare("low");
    data_bus = bnk2; exp_bank = bnk2;
    #1 compare("low2");
    @(posedge phi2);
    #1 data_bus = junk;
    #1 compare("high");
    #1 data_bus = ~junk;
    #0.5 compare("high_late");
  endtask

  initial begin
    // R8: reset state, with a non-zero bus in the low phase
    data_bus = 8'h05;
    @(negedge phi2); #2 compare("reset_low");
    @(posedge phi2); #1 rst_n = 1'b1; #1 compare("reset_release_high");

    for (int b = 0; b < 8; b++)
      cycle(8'(b), 8'(b), 8'(b ^ 8'h5A), 16'(16'h1234 + b * 16'h1111));

    // R6 window edges in bank 0, R7 junk on high phase
    cycle(8'h00, 8'h00, 8'h03, 16'hFFBF);
    cycle(8'h00, 8'h00, 8'h03, 16'hFFC0);
    cycle(8'h00, 8'h00, 8'h01, 16'hFFE0);
    cycle(8'h00, 8'h00, 8'hFF, 16'hFFFF);
    // R7: bank 1 held while bus shows 0 in high phase
    cycle(8'h01, 8'h01, 8'h00, 16'hFFFF);
    // R4 out-of-range banks, R5 odd values
    cycle(8'h08, 8'h08, 8'h00, 16'hFFC0);
    cycle(8'h80, 8'h80, 8'h01, 16'h0000);
    cycle(8'hFF, 8'hFF, 8'h00, 16'hFFF0);
    // R1 transparency: byte changes within one low phase
    cycle(8'h06, 8'h02, 8'h07, 16'h8000);
    cycle(8'h03, 8'h00, 8'h05, 16'hFFFC);

    // R8: async reset inside a high phase
    cycle(8'h05, 8'h05, 8'h00, 16'hFFD0);
    @(negedge phi2); #1 data_bus = 8'h07; exp_bank = 7; #1 compare("pre_reset");
    @(posedge phi2); #1 rst_n = 1'b0; exp_bank = 0; #1 compare("reset_high");
    #1 rst_n = 1'b1; #0.5 compare("reset_after_release");
    cycle(8'h04, 8'h04, 8'h00, 16'hFFFF);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #200000;
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule